// File: doc/BRIEF.md
# In-Order Issue Interlock Scoreboard

This block decides, one cycle at a time, whether a single in-order pipeline may issue the instruction offered to it. The pipeline has three stages, execute (E), memory (M) and writeback (W), and each is a resource that can be booked. Every instruction passes through them in that order. Each request carries a class code, one destination register and two source registers. The block answers accept or stall in the same cycle, using only its own state. It does not model the datapath, caches, fetch, decode or condition codes, and it assumes every instruction executes.

Each class has a fixed timing entry. The entry gives how many consecutive cycles the instruction holds E, how many it then holds M, whether it then holds W for one cycle, and its result latency L. When a request is accepted, its stage pattern is added to three reservation shift windows and its destination register gets a ready countdown. A request is stalled if any slot it needs is already taken at that cycle offset. It is also stalled if either of its sources is still counting down. A stalled request changes nothing, so the issuer simply presents it again.

Top module: `issue_scoreboard`

## Requirements
- R1: Class codes and stage patterns, given as (E cycles, M cycles, W used, latency L):
  - 0 ALU: (1,1,yes,1)
  - 1 ALU with shift by register: (2,1,yes,2)
  - 2 multiply: (2,1,yes,3)
  - 3 long or flag-setting multiply: (3,1,yes,4)
  - 4 flag-setting long multiply: (4,1,yes,5)
  - 5 halfword multiply: (1,1,yes,2)
  - 6 single load: (2,1,yes,3)
  - 7, 8, 9 loads of 2, 3, 4 words: (1,N,yes,N+1)
  - 10 to 13 stores of 1 to 4 words: (1,N,yes,0)
  - 14 branch: (0,0,no,0)
  - 15 call: (0,0,no,32)
  
  E is booked at offsets 0 to e-1 from the issue cycle, M at the following m offsets, and W at the single offset after that.
- R2: A valid request stalls when any E, M or W slot it needs, at its own offset, is already booked by an earlier accepted instruction.
- R3: A consumer whose source was written by an instruction of latency L, with L of 1 or more, stalls if offered fewer than L cycles after that producer was accepted. It may issue L cycles after the producer.
- R4: Sources are checked against the countdowns only. A request that has no stage conflict and no busy source is accepted.
- R5: Classes with zero latency (stores and branches) never mark their destination busy.
- R6: A call marks its destination busy, so a reader of that register offered k cycles after the call stalls for k from 1 to 31 and is accepted at k = 32. A call books no stage.
- R7: iss_accept and iss_stall are never high together, and both are low when iss_valid is low. A stalled or invalid request books no slot and loads no countdown.
- R8: Accepting a new writer reloads its destination countdown with the new latency, even when that value is shorter than the one pending.
- R9: A synchronous active-low reset clears every reservation slot and every countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| iss_valid | input | 1 | An issue request is present |
| iss_class | input | 4 | Instruction class code (R1) |
| iss_dst | input | REG_W | Destination register index |
| iss_src_a | input | REG_W | First source register index |
| iss_src_b | input | REG_W | Second source register index |
| iss_accept | output | 1 | Request issues this cycle |
| iss_stall | output | 1 | Request is held back this cycle |

## Verification
A structural conflict and a data hazard can occur in the same cycle. The bench causes this by offering, right after a two-cycle-E multiply, a consumer that needs E and also reads the multiply's destination. It then removes the two causes one at a time: the next cycle leaves only the data hazard, and the cycle after that accepts. A second pair of events can also coincide: a countdown is reloaded while it is still counting down. The bench checks this by issuing a call and then a one-cycle ALU writer to the same register, and by seeing that a reader of that register is accepted immediately afterwards.

// File: rtl/iss_sb_pkg.sv
// Package: class codes and the fixed per-class timing table of the scoreboard.
// Assumes every booked pattern fits in WIN cycles and every latency fits in LAT_W bits.
package iss_sb_pkg;

    localparam int CLS_W = 4;
    localparam int WIN   = 6;   // longest pattern: E4+M1+W1 or E1+M4+W1
    localparam int LAT_W = 6;   // holds latency 32
    localparam int NSTG  = 3;   // E, M, W

    typedef enum logic [CLS_W-1:0] {
        C_ALU    = 4'd0,  C_ALU_SR = 4'd1,  C_MUL    = 4'd2,  C_MUL_L  = 4'd3,
        C_MUL_LF = 4'd4,  C_MUL_H  = 4'd5,  C_LD1    = 4'd6,  C_LD2    = 4'd7,
        C_LD3    = 4'd8,  C_LD4    = 4'd9,  C_ST1    = 4'd10, C_ST2    = 4'd11,
        C_ST3    = 4'd12, C_ST4    = 4'd13, C_BR     = 4'd14, C_CALL   = 4'd15
    } iclass_e;

    typedef struct packed {
        logic [2:0]       e_len;
        logic [2:0]       m_len;
        logic             w_use;
        logic [LAT_W-1:0] lat;
    } timing_t;

    // Returns the stage occupancy and result latency of a class.
    function automatic timing_t class_timing(iclass_e c);
        timing_t t;
        case (c)
            C_ALU:    t = '{3'd1, 3'd1, 1'b1, 6'd1};
            C_ALU_SR: t = '{3'd2, 3'd1, 1'b1, 6'd2};
            C_MUL:    t = '{3'd2, 3'd1, 1'b1, 6'd3};
            C_MUL_L:  t = '{3'd3, 3'd1, 1'b1, 6'd4};
            C_MUL_LF: t = '{3'd4, 3'd1, 1'b1, 6'd5};
            C_MUL_H:  t = '{3'd1, 3'd1, 1'b1, 6'd2};
            C_LD1:    t = '{3'd2, 3'd1, 1'b1, 6'd3};
            C_LD2:    t = '{3'd1, 3'd2, 1'b1, 6'd3};
            C_LD3:    t = '{3'd1, 3'd3, 1'b1, 6'd4};
            C_LD4:    t = '{3'd1, 3'd4, 1'b1, 6'd5};
            C_ST1:    t = '{3'd1, 3'd1, 1'b1, 6'd0};
            C_ST2:    t = '{3'd1, 3'd2, 1'b1, 6'd0};
            C_ST3:    t = '{3'd1, 3'd3, 1'b1, 6'd0};
            C_ST4:    t = '{3'd1, 3'd4, 1'b1, 6'd0};
            C_BR:     t = '{3'd0, 3'd0, 1'b0, 6'd0};
            default:  t = '{3'd0, 3'd0, 1'b0, 6'd32};   // call
        endcase
        return t;
    endfunction

endpackage

// File: rtl/sb_timing_decode.sv
// Module: turns a class code into per-stage need masks over the booking window
// and the result latency. Purely combinational; bit k of a mask means the
// stage is needed k cycles after the issue cycle.
module sb_timing_decode
    import iss_sb_pkg::*;
(
    input  logic [CLS_W-1:0]          cls,
    output logic [NSTG-1:0][WIN-1:0]  need,
    output logic [LAT_W-1:0]          lat
);
    timing_t t;

    // Expand the lengths into the three offset masks.
    always_comb begin
        t   = class_timing(iclass_e'(cls));
        lat = t.lat;
        for (int k = 0; k < WIN; k++) begin
            need[0][k] = (k < int'(t.e_len));
            need[1][k] = (k >= int'(t.e_len)) && (k < int'(t.e_len) + int'(t.m_len));
            need[2][k] = t.w_use && (k == int'(t.e_len) + int'(t.m_len));
        end
    end
endmodule

// File: rtl/sb_stage_resv.sv
// Module: reservation window for one pipeline stage. Bit k of the window is
// set when the stage is booked k cycles from now. The window shifts by one
// each cycle. On book, the need mask is merged in before the shift.
// Assumes the caller books only when conflict is low.
module sb_stage_resv #(
    parameter int WIN = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [WIN-1:0] need,
    input  logic           book,
    output logic           conflict
);
    logic [WIN-1:0] slots;

    // Flag an overlap between the request and the existing bookings.
    assign conflict = |(need & slots);

    // Merge an accepted pattern, then advance the window by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) slots <= '0;
        else        slots <= (slots | (book ? need : '0)) >> 1;
    end

    a_r2_no_double_book: assert property (@(posedge clk) disable iff (!rst_n)
        book |-> ((need & slots) == '0));
    a_r1_pattern_held: assert property (@(posedge clk) disable iff (!rst_n)
        book |=> ((slots & ($past(need) >> 1)) == ($past(need) >> 1)));
    a_r7_idle_window_advances: assert property (@(posedge clk) disable iff (!rst_n)
        !book |=> (slots == ($past(slots) >> 1)));
endmodule

// File: rtl/sb_ready_ctr.sv
// Module: one ready countdown per architectural register. A write loads a
// value. Otherwise a nonzero count steps down by one each cycle. A read
// port reports busy while its register's count is nonzero.
module sb_ready_ctr #(
    parameter int NUM_REGS = 16,
    parameter int CNT_W    = 5,
    localparam int REG_W   = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_idx,
    input  logic [CNT_W-1:0] wr_val,
    input  logic [REG_W-1:0] rd_a_idx,
    input  logic [REG_W-1:0] rd_b_idx,
    output logic             rd_a_busy,
    output logic             rd_b_busy
);
    logic [CNT_W-1:0] cnt [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic hit;
        assign hit = wr_en && (wr_idx == REG_W'(g));

        // Reload on a new writer, otherwise count down to zero.
        always_ff @(posedge clk) begin
            if (!rst_n)          cnt[g] <= '0;
            else if (hit)        cnt[g] <= wr_val;
            else if (cnt[g] != 0) cnt[g] <= cnt[g] - 1'b1;
        end

        a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
            hit |=> (cnt[g] == $past(wr_val)));
        a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
            (!hit && cnt[g] != 0) |=> (cnt[g] == $past(cnt[g]) - 1'b1));
    end

    // Report the busy state of the two source registers.
    assign rd_a_busy = (cnt[rd_a_idx] != 0);
    assign rd_b_busy = (cnt[rd_b_idx] != 0);
endmodule

// File: rtl/issue_scoreboard.sv
// Module: in-order issue interlock. Each cycle it combines the stage conflict
// flags with the source busy flags to accept or stall the offered
// instruction. On accept it books the class pattern and loads the
// destination countdown with latency-1. A consumer offered L cycles later
// therefore sees zero. Zero-latency classes load nothing.
module issue_scoreboard
    import iss_sb_pkg::*;
#(
    parameter int NUM_REGS = 16,
    localparam int REG_W   = $clog2(NUM_REGS),
    localparam int CNT_W   = LAT_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iss_valid,
    input  logic [CLS_W-1:0] iss_class,
    input  logic [REG_W-1:0] iss_dst,
    input  logic [REG_W-1:0] iss_src_a,
    input  logic [REG_W-1:0] iss_src_b,
    output logic             iss_accept,
    output logic             iss_stall
);
    logic [NSTG-1:0][WIN-1:0] need;
    logic [LAT_W-1:0]         lat;
    logic [LAT_W-1:0]         lat_m1;
    logic [NSTG-1:0]          conflict;
    logic                     busy_a, busy_b, hazard;

    sb_timing_decode u_dec (
        .cls  (iss_class),
        .need (need),
        .lat  (lat)
    );

    for (genvar s = 0; s < NSTG; s++) begin : g_stage
        sb_stage_resv #(.WIN(WIN)) u_resv (
            .clk      (clk),
            .rst_n    (rst_n),
            .need     (need[s]),
            .book     (iss_accept),
            .conflict (conflict[s])
        );
    end

    // Latency minus one, so a consumer may issue exactly L cycles later.
    assign lat_m1 = lat - 1'b1;

    sb_ready_ctr #(.NUM_REGS(NUM_REGS), .CNT_W(CNT_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (iss_accept && (lat != '0)),
        .wr_idx    (iss_dst),
        .wr_val    (lat_m1[CNT_W-1:0]),
        .rd_a_idx  (iss_src_a),
        .rd_b_idx  (iss_src_b),
        .rd_a_busy (busy_a),
        .rd_b_busy (busy_b)
    );

    // Combine the structural and data hazards into the issue decision.
    assign hazard     = (|conflict) || busy_a || busy_b;
    assign iss_accept = iss_valid && !hazard;
    assign iss_stall  = iss_valid && hazard;

    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(iss_accept && iss_stall));
    a_r7_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !iss_valid |-> (!iss_accept && !iss_stall));
    a_r3_busy_source_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && (busy_a || busy_b)) |-> iss_stall);
    a_r2_conflict_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && (|conflict)) |-> !iss_accept);
endmodule

// File: tb/issue_scoreboard_tb_top.sv
module issue_scoreboard_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       iss_valid = 1'b0;
    logic [3:0] iss_class = '0, iss_dst = '0, iss_src_a = '0, iss_src_b = '0;
    logic       iss_accept, iss_stall;
    int         n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;   // 250 MHz

    issue_scoreboard dut_i (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_class(iss_class),
        .iss_dst(iss_dst), .iss_src_a(iss_src_a), .iss_src_b(iss_src_b),
        .iss_accept(iss_accept), .iss_stall(iss_stall)
    );

    // {valid, class, dst, src_a, src_b, expected accept}
    localparam int NV = 22;
    localparam logic [17:0] VEC [NV] = '{
        {1'b1, 4'd0,  4'd1,  4'd2,  4'd3, 1'b1},  // 0  ALU
        {1'b1, 4'd0,  4'd2,  4'd1,  4'd3, 1'b1},  // 1  ALU back-to-back, lat 1 (R3)
        {1'b1, 4'd1,  4'd4,  4'd5,  4'd6, 1'b1},  // 2  shift-by-reg, E x2
        {1'b1, 4'd0,  4'd7,  4'd8,  4'd9, 1'b0},  // 3  E conflict (R2)
        {1'b1, 4'd0,  4'd7,  4'd4,  4'd9, 1'b1},  // 4  r4 ready at L=2 (R3)
        {1'b1, 4'd2,  4'd10, 4'd11, 4'd12,1'b1},  // 5  multiply, L=3
        {1'b1, 4'd0,  4'd13, 4'd10, 4'd0, 1'b0},  // 6  E conflict and data hazard
        {1'b1, 4'd0,  4'd13, 4'd10, 4'd0, 1'b0},  // 7  data hazard only (R3)
        {1'b1, 4'd0,  4'd13, 4'd10, 4'd0, 1'b1},  // 8  accepted (R4)
        {1'b1, 4'd9,  4'd1,  4'd2,  4'd3, 1'b1},  // 9  four-word load, M x4
        {1'b1, 4'd0,  4'd5,  4'd6,  4'd7, 1'b0},  // 10 M conflict (R2)
        {1'b1, 4'd10, 4'd0,  4'd6,  4'd7, 1'b0},  // 11 store M conflict (R2)
        {1'b1, 4'd14, 4'd0,  4'd6,  4'd7, 1'b1},  // 12 branch books nothing (R1)
        {1'b1, 4'd0,  4'd5,  4'd1,  4'd7, 1'b0},  // 13 load L=5 not done (R3)
        {1'b1, 4'd0,  4'd5,  4'd1,  4'd7, 1'b1},  // 14 accepted at L=5
        {1'b1, 4'd4,  4'd8,  4'd9,  4'd9, 1'b1},  // 15 flag long multiply, E x4
        {1'b1, 4'd14, 4'd0,  4'd0,  4'd0, 1'b1},  // 16 branch
        {1'b1, 4'd15, 4'd3,  4'd0,  4'd0, 1'b1},  // 17 call (R6)
        {1'b1, 4'd5,  4'd9,  4'd3,  4'd0, 1'b0},  // 18 call dst busy (R6)
        {1'b0, 4'd0,  4'd0,  4'd0,  4'd0, 1'b0},  // 19 idle (R7)
        {1'b1, 4'd13, 4'd4,  4'd8,  4'd0, 1'b1},  // 20 four-word store, r8 ready L=5
        {1'b1, 4'd14, 4'd0,  4'd4,  4'd4, 1'b1}   // 21 store left r4 free (R5)
    };

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [3:0] c, input logic [3:0] d,
                         input logic [3:0] a, input logic [3:0] b);
        @(negedge clk);
        iss_valid = v; iss_class = c; iss_dst = d; iss_src_a = a; iss_src_b = b;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; iss_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R9: reset state, nothing offered and nothing reported
        drive(1'b0, 4'd0, 4'd0, 4'd0, 4'd0);
        chk("R9 idle accept after reset", iss_accept, 1'b0);
        chk("R7 idle stall after reset", iss_stall, 1'b0);

        // Vector table: R1 R2 R3 R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            logic [17:0] v;
            v = VEC[i];
            drive(v[17], v[16:13], v[12:9], v[8:5], v[4:1]);
            chk($sformatf("R1 R2 R3 vector %0d accept", i), iss_accept, v[0]);
            chk($sformatf("R7 vector %0d stall", i), iss_stall, v[17] & ~v[0]);
        end

        // R9: reset in flight clears both the M bookings and the r1 countdown
        do_reset();
        drive(1'b1, 4'd9, 4'd1, 4'd0, 4'd0);
        chk("R9 load before reset", iss_accept, 1'b1);
        do_reset();
        drive(1'b1, 4'd0, 4'd2, 4'd1, 4'd0);
        chk("R9 after reset accept", iss_accept, 1'b1);

        // R6: call blocks a reader for 31 cycles, releases it at 32
        do_reset();
        drive(1'b1, 4'd15, 4'd3, 4'd0, 4'd0);
        chk("R6 call accepted", iss_accept, 1'b1);
        for (int k = 1; k <= 32; k++) begin
            drive(1'b1, 4'd14, 4'd0, 4'd3, 4'd0);
            chk($sformatf("R6 reader at k=%0d", k), iss_accept, (k == 32));
        end

        // R8: ALU writer after a call reloads r2 to a shorter wait
        drive(1'b1, 4'd15, 4'd2, 4'd0, 4'd0);
        chk("R8 call to r2", iss_accept, 1'b1);
        drive(1'b1, 4'd0, 4'd2, 4'd0, 4'd0);
        chk("R8 ALU rewrite r2", iss_accept, 1'b1);
        drive(1'b1, 4'd14, 4'd0, 4'd2, 4'd2);
        chk("R8 reader of r2 free", iss_accept, 1'b1);

        // R5: single store then branch reading its dst at once
        drive(1'b1, 4'd10, 4'd6, 4'd0, 4'd0);
        chk("R5 store accepted", iss_accept, 1'b1);
        drive(1'b1, 4'd14, 4'd0, 4'd6, 4'd6);
        chk("R5 store dst not busy", iss_accept, 1'b1);

        drive(1'b0, 4'd0, 4'd0, 4'd0, 4'd0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule